// File: doc/BRIEF.md
# SD Card Command Issue Register Unit

This block is the software-facing command launch point of an SD card host controller. Software first loads a 32-bit argument, then writes a command word that carries the command index, the response type (none, short or long), a busy-wait request and a data direction, together with a "new command" flag. The unit registers the command, gives a one-cycle start pulse to a command-line engine and keeps the new flag set while the command is in flight. A command word written while a command is still in flight is dropped.

When the engine reports completion, the unit clears the new flag. If the engine flagged a command timeout or a CRC7 error, the unit sets a fail flag in the command word. Otherwise it captures the response into four 32-bit response words. A sticky status register gathers command errors, data-path events and the end of card busy signalling. Software clears these bits by writing ones. The serial shifter and CRC logic lie outside the block and are reduced to a done/error/response handshake.

Top module: `sd_cmd_issue`

## Requirements
- R1: After reset the command word, argument, the four response words and the sticky status bits all read zero, and `eng_start_o` is low.
- R2: A write to offset 0x00 with bit 15 set, while no command is in flight, stores the command fields and sets bit 15. In the following cycle `eng_start_o` is high for exactly one cycle, and the engine outputs show the index (bits 5:0), read (bit 6), write (bit 7), long response (bit 9), no response (bit 10), busy-wait (bit 11) and the argument.
- R3: Bit 15 stays set until `eng_done_i` arrives, and it reads zero from the cycle after that. Any write to offset 0x00 while bit 15 is set has no effect on the command word.
- R4: A completion with `eng_timeout_i` or `eng_crc7_i` set sets bit 14 of the command word and, respectively, status bit 6 or status bit 4. Bit 14 is cleared by the next accepted command-word write.
- R5: On a completion without error, a long-response command loads all four response words. Offset 0x10 holds response bits 31:0, 0x14 bits 63:32, 0x18 bits 95:64 and 0x1C bits 127:96. A short-response command loads only offset 0x10. A completion with an error loads none of them.
- R6: A completion of a command with the no-response bit (bit 10) set leaves all four response words unchanged.
- R7: The end of card busy (`card_busy_end_i`) sets status bit 10 only after a busy-wait command has completed without error. Otherwise it has no effect.
- R8: The data-path event inputs set status bits 9 (block), 8 (SDIO), 7 (read/erase/write timeout), 5 (CRC16) and 3 (FIFO), and these bits stay set. Status bit 0 follows `data_flag_i` directly and cannot be cleared.
- R9: Writing offset 0x20 clears each status bit from 3 to 10 whose write-data bit is 1 and leaves bits written with 0 unchanged. If an event sets a bit in the same cycle that a write clears it, the bit ends up set.
- R10: The argument at offset 0x04 reads back as written. Offsets other than 0x00, 0x04, 0x10 to 0x1C and 0x20 read zero. A command-word write with bit 15 clear stores the fields without giving a start pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| bus_we_i | input | 1 | Register write strobe |
| bus_addr_i | input | 8 | Register byte offset |
| bus_wdata_i | input | 32 | Write data |
| bus_rdata_o | output | 32 | Read data for `bus_addr_i`, combinational |
| eng_start_o | output | 1 | One-cycle launch pulse to the command-line engine |
| eng_idx_o | output | 6 | Command index |
| eng_arg_o | output | 32 | Command argument |
| eng_rd_o | output | 1 | Command is followed by a read data transfer |
| eng_wr_o | output | 1 | Command is followed by a write data transfer |
| eng_long_o | output | 1 | 136-bit response expected |
| eng_noresp_o | output | 1 | No response expected |
| eng_busy_o | output | 1 | Busy-wait after response |
| eng_done_i | input | 1 | Command completion pulse |
| eng_timeout_i | input | 1 | Completion ended in command timeout (valid with done) |
| eng_crc7_i | input | 1 | Completion ended in CRC7 error (valid with done) |
| eng_resp_i | input | 128 | Response bits (valid with done) |
| card_busy_end_i | input | 1 | Card released busy signalling |
| blk_evt_i | input | 1 | Block-done event |
| sdio_evt_i | input | 1 | SDIO interrupt event |
| rew_timeout_i | input | 1 | Read/erase/write timeout event |
| crc16_err_i | input | 1 | Data CRC16 error event |
| fifo_err_i | input | 1 | FIFO error event |
| data_flag_i | input | 1 | Live FIFO data flag |

## Verification
The hardest situations to reach are those where two agents meet in one cycle. One is a command-word write that lands while a command is in flight. The other is a status clear that coincides with a new event on the same bit. The stimulus writes a different command word right after a launch, before completion, and then reads the word back. It also holds an event input high across the edge on which the clear write lands. The busy interrupt needs a set order: a busy-wait command launched and completed cleanly, then a busy-end pulse. A stray busy-end pulse before any such command shows the gating.

// File: rtl/sdci_pkg.sv
package sdci_pkg;
  localparam int unsigned ADDR_W = 8;
  localparam int unsigned DATA_W = 32;
  localparam int unsigned STS_W  = 11;

  localparam logic [ADDR_W-1:0] OFF_CMD  = 8'h00;
  localparam logic [ADDR_W-1:0] OFF_ARG  = 8'h04;
  localparam logic [ADDR_W-1:0] OFF_RESP = 8'h10;
  localparam logic [ADDR_W-1:0] OFF_STS  = 8'h20;

  localparam int unsigned CB_NEW  = 15;
  localparam int unsigned CB_FAIL = 14;
  localparam int unsigned CB_BUSY = 11;
  localparam int unsigned CB_NORS = 10;
  localparam int unsigned CB_LONG = 9;
  localparam int unsigned CB_WR   = 7;
  localparam int unsigned CB_RD   = 6;

  localparam int unsigned SB_BUSY  = 10;
  localparam int unsigned SB_BLK   = 9;
  localparam int unsigned SB_SDIO  = 8;
  localparam int unsigned SB_REWTO = 7;
  localparam int unsigned SB_CMDTO = 6;
  localparam int unsigned SB_CRC16 = 5;
  localparam int unsigned SB_CRC7  = 4;
  localparam int unsigned SB_FIFO  = 3;
  localparam int unsigned SB_DATA  = 0;

  localparam logic [STS_W-1:0] STICKY_MASK = 11'h7F8;

  typedef struct packed {
    logic       busy;
    logic       noresp;
    logic       long_r;
    logic       wr;
    logic       rd;
    logic [5:0] idx;
  } cmd_t;
endpackage

// File: rtl/sdci_cmd_ctrl.sv
module sdci_cmd_ctrl
  import sdci_pkg::*;
(
  input  logic        clk_i,
  input  logic        rst_ni,
  input  logic        wr_en_i,
  input  logic [15:0] wdata_i,
  input  logic        done_i,
  input  logic        err_i,
  output logic        new_o,
  output logic        fail_o,
  output logic        start_o,
  output cmd_t        cmd_o
);
  logic new_q, fail_q, start_q, accept;
  cmd_t cmd_q;

  assign accept = wr_en_i && !new_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      new_q   <= 1'b0;
      fail_q  <= 1'b0;
      start_q <= 1'b0;
      cmd_q   <= '0;
    end else begin
      start_q <= 1'b0;
      if (accept) begin
        cmd_q.busy   <= wdata_i[CB_BUSY];
        cmd_q.noresp <= wdata_i[CB_NORS];
        cmd_q.long_r <= wdata_i[CB_LONG];
        cmd_q.wr     <= wdata_i[CB_WR];
        cmd_q.rd     <= wdata_i[CB_RD];
        cmd_q.idx    <= wdata_i[5:0];
        new_q        <= wdata_i[CB_NEW];
        start_q      <= wdata_i[CB_NEW];
        fail_q       <= 1'b0;
      end else if (new_q && done_i) begin
        new_q  <= 1'b0;
        fail_q <= err_i;
      end
    end
  end

  assign new_o   = new_q;
  assign fail_o  = fail_q;
  assign start_o = start_q;
  assign cmd_o   = cmd_q;

  AST_START_WITH_NEW: assert property (@(posedge clk_i) disable iff (!rst_ni)
    start_o |-> new_o); // R2
  AST_START_ONE_CYCLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    start_o |=> !start_o); // R2
  AST_NEW_HOLDS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (new_o && !done_i) |=> new_o); // R3
  AST_INFLIGHT_WRITE_DROPPED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (new_o && wr_en_i) |=> $stable(cmd_o)); // R3
  AST_FAIL_ON_ERROR: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (new_o && done_i && err_i) |=> (fail_o && !new_o)); // R4
endmodule

// File: rtl/sdci_resp_store.sv
module sdci_resp_store #(
  parameter int unsigned WORDS = 4,
  parameter int unsigned W     = 32
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               cap_short_i,
  input  logic               cap_long_i,
  input  logic [WORDS*W-1:0] resp_i,
  output logic [WORDS*W-1:0] words_o
);
  for (genvar g = 0; g < WORDS; g++) begin : g_word
    logic [W-1:0] word_q;
    logic         load;
    if (g == 0) begin : g_low
      assign load = cap_short_i || cap_long_i;
    end else begin : g_high
      assign load = cap_long_i;
    end
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)   word_q <= '0;
      else if (load) word_q <= resp_i[g*W +: W];
    end
    assign words_o[g*W +: W] = word_q;
  end

  AST_UPPER_NEEDS_LONG: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !cap_long_i |=> $stable(words_o[WORDS*W-1:W])); // R5
endmodule

// File: rtl/sdci_status.sv
module sdci_status
  import sdci_pkg::*;
(
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             clr_en_i,
  input  logic [STS_W-1:0] clr_mask_i,
  input  logic [STS_W-1:0] set_i,
  input  logic             data_flag_i,
  output logic [STS_W-1:0] sts_o
);
  logic [STS_W-1:0] sticky_q, clr_eff;

  assign clr_eff = clr_en_i ? (clr_mask_i & STICKY_MASK) : '0;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) sticky_q <= '0;
    else         sticky_q <= (sticky_q & ~clr_eff) | (set_i & STICKY_MASK);
  end

  always_comb begin
    sts_o          = sticky_q & STICKY_MASK;
    sts_o[SB_DATA] = data_flag_i;
  end

  AST_SET_WINS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    set_i[SB_BLK] |=> sts_o[SB_BLK]); // R9
  AST_W1C_CLEARS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (clr_en_i && clr_mask_i[SB_FIFO] && !set_i[SB_FIFO]) |=> !sts_o[SB_FIFO]); // R9
  AST_ZERO_KEEPS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sts_o[SB_SDIO] && !(clr_en_i && clr_mask_i[SB_SDIO])) |=> sts_o[SB_SDIO]); // R8
endmodule

// File: rtl/sd_cmd_issue.sv
module sd_cmd_issue
  import sdci_pkg::*;
#(
  parameter int unsigned RESP_WORDS = 4
) (
  input  logic                       clk_i,
  input  logic                       rst_ni,
  input  logic                       bus_we_i,
  input  logic [7:0]                 bus_addr_i,
  input  logic [31:0]                bus_wdata_i,
  output logic [31:0]                bus_rdata_o,
  output logic                       eng_start_o,
  output logic [5:0]                 eng_idx_o,
  output logic [31:0]                eng_arg_o,
  output logic                       eng_rd_o,
  output logic                       eng_wr_o,
  output logic                       eng_long_o,
  output logic                       eng_noresp_o,
  output logic                       eng_busy_o,
  input  logic                       eng_done_i,
  input  logic                       eng_timeout_i,
  input  logic                       eng_crc7_i,
  input  logic [RESP_WORDS*32-1:0]   eng_resp_i,
  input  logic                       card_busy_end_i,
  input  logic                       blk_evt_i,
  input  logic                       sdio_evt_i,
  input  logic                       rew_timeout_i,
  input  logic                       crc16_err_i,
  input  logic                       fifo_err_i,
  input  logic                       data_flag_i
);
  localparam int unsigned RESP_BITS = RESP_WORDS * DATA_W;
  localparam int unsigned RESP_END  = OFF_RESP + 4 * RESP_WORDS;

  logic                 cmd_new, cmd_fail, cmd_err, done_act, done_ok;
  logic                 wr_cmd, wr_arg, wr_sts, busy_pend_q;
  logic [DATA_W-1:0]    arg_q;
  logic [RESP_BITS-1:0] resp_words;
  logic [STS_W-1:0]     sts, sts_set;
  cmd_t                 cmd;

  assign wr_cmd   = bus_we_i && (bus_addr_i == OFF_CMD);
  assign wr_arg   = bus_we_i && (bus_addr_i == OFF_ARG);
  assign wr_sts   = bus_we_i && (bus_addr_i == OFF_STS);
  assign cmd_err  = eng_timeout_i || eng_crc7_i;
  assign done_act = cmd_new && eng_done_i;
  assign done_ok  = done_act && !cmd_err;

  sdci_cmd_ctrl u_ctrl (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .wr_en_i (wr_cmd),
    .wdata_i (bus_wdata_i[15:0]),
    .done_i  (eng_done_i),
    .err_i   (cmd_err),
    .new_o   (cmd_new),
    .fail_o  (cmd_fail),
    .start_o (eng_start_o),
    .cmd_o   (cmd)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     arg_q <= '0;
    else if (wr_arg) arg_q <= bus_wdata_i;
  end

  sdci_resp_store #(.WORDS(RESP_WORDS), .W(DATA_W)) u_resp (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .cap_short_i (done_ok && !cmd.noresp && !cmd.long_r),
    .cap_long_i  (done_ok && !cmd.noresp && cmd.long_r),
    .resp_i      (eng_resp_i),
    .words_o     (resp_words)
  );

  // busy interrupt armed only by a clean busy-wait completion
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                         busy_pend_q <= 1'b0;
    else if (done_ok && cmd.busy)        busy_pend_q <= 1'b1;
    else if (card_busy_end_i || done_act) busy_pend_q <= 1'b0;
  end

  always_comb begin
    sts_set           = '0;
    sts_set[SB_BUSY]  = card_busy_end_i && busy_pend_q;
    sts_set[SB_BLK]   = blk_evt_i;
    sts_set[SB_SDIO]  = sdio_evt_i;
    sts_set[SB_REWTO] = rew_timeout_i;
    sts_set[SB_CMDTO] = done_act && eng_timeout_i;
    sts_set[SB_CRC16] = crc16_err_i;
    sts_set[SB_CRC7]  = done_act && eng_crc7_i;
    sts_set[SB_FIFO]  = fifo_err_i;
  end

  sdci_status u_sts (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .clr_en_i    (wr_sts),
    .clr_mask_i  (bus_wdata_i[STS_W-1:0]),
    .set_i       (sts_set),
    .data_flag_i (data_flag_i),
    .sts_o       (sts)
  );

  always_comb begin
    bus_rdata_o = '0;
    if (bus_addr_i == OFF_CMD) begin
      bus_rdata_o[CB_NEW]  = cmd_new;
      bus_rdata_o[CB_FAIL] = cmd_fail;
      bus_rdata_o[CB_BUSY] = cmd.busy;
      bus_rdata_o[CB_NORS] = cmd.noresp;
      bus_rdata_o[CB_LONG] = cmd.long_r;
      bus_rdata_o[CB_WR]   = cmd.wr;
      bus_rdata_o[CB_RD]   = cmd.rd;
      bus_rdata_o[5:0]     = cmd.idx;
    end else if (bus_addr_i == OFF_ARG) begin
      bus_rdata_o = arg_q;
    end else if (bus_addr_i == OFF_STS) begin
      bus_rdata_o[STS_W-1:0] = sts;
    end else if (bus_addr_i >= OFF_RESP && 32'(bus_addr_i) < RESP_END
                 && bus_addr_i[1:0] == 2'b00) begin
      for (int i = 0; i < RESP_WORDS; i++)
        if (32'(bus_addr_i) == OFF_RESP + 4 * i)
          bus_rdata_o = resp_words[i*DATA_W +: DATA_W];
    end
  end

  assign eng_idx_o    = cmd.idx;
  assign eng_arg_o    = arg_q;
  assign eng_rd_o     = cmd.rd;
  assign eng_wr_o     = cmd.wr;
  assign eng_long_o   = cmd.long_r;
  assign eng_noresp_o = cmd.noresp;
  assign eng_busy_o   = cmd.busy;

  AST_NORESP_KEEPS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (done_act && cmd.noresp) |=> $stable(resp_words)); // R6
  AST_ERROR_KEEPS_RESP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (done_act && cmd_err) |=> $stable(resp_words)); // R5
  AST_BUSY_IRQ_SOURCE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(sts[SB_BUSY]) |-> $past(card_busy_end_i && busy_pend_q)); // R7
  AST_CMDTO_FLAG: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (done_act && eng_timeout_i) |=> sts[SB_CMDTO]); // R4
endmodule

// File: tb/sd_cmd_issue_bench.sv
module sd_cmd_issue_bench;
  localparam int CLK_PERIOD = 10;

  typedef struct packed {
    logic [15:0]  cmdw;
    logic [31:0]  arg;
    logic         to;
    logic         crc;
    logic [127:0] resp;
  } vec_t;

  localparam int NV = 6;
  localparam vec_t VECS [NV] = '{
    '{16'h0051, 32'h0000_1234, 1'b0, 1'b0, 128'h9999_0000_8888_0000_7777_0000_AAAA_0001},
    '{16'h0202, 32'h0000_0000, 1'b0, 1'b0, 128'h4444_4444_3333_3333_2222_2222_1111_1111},
    '{16'h0400, 32'hFFFF_0000, 1'b0, 1'b0, 128'hDEAD_BEEF_DEAD_BEEF_DEAD_BEEF_DEAD_BEEF},
    '{16'h0008, 32'h0001_0002, 1'b1, 1'b0, 128'h5555_5555_5555_5555_5555_5555_5555_5555},
    '{16'h0209, 32'hCAFE_F00D, 1'b0, 1'b1, 128'h6666_6666_6666_6666_6666_6666_6666_6666},
    '{16'h0887, 32'h0000_0777, 1'b0, 1'b0, 128'hABCD_0004_ABCD_0003_ABCD_0002_0000_0777}
  };

  logic clk = 1'b0, rst_n = 1'b0;
  logic bus_we = 1'b0;
  logic [7:0] bus_addr = '0;
  logic [31:0] bus_wdata = '0, bus_rdata;
  logic eng_start, eng_rd, eng_wr, eng_long, eng_noresp, eng_busy;
  logic [5:0] eng_idx;
  logic [31:0] eng_arg;
  logic eng_done = 0, eng_to = 0, eng_crc = 0;
  logic [127:0] eng_resp = '0;
  logic busy_end = 0, blk = 0, sdio = 0, rewto = 0, crc16 = 0, fifo = 0, dflag = 0;

  int checks = 0, fails = 0;
  logic [31:0] resp_m [4];

  always #(CLK_PERIOD/2) clk = ~clk;

  sd_cmd_issue u_sd_cmd_issue (
    .clk_i(clk), .rst_ni(rst_n), .bus_we_i(bus_we), .bus_addr_i(bus_addr),
    .bus_wdata_i(bus_wdata), .bus_rdata_o(bus_rdata), .eng_start_o(eng_start),
    .eng_idx_o(eng_idx), .eng_arg_o(eng_arg), .eng_rd_o(eng_rd), .eng_wr_o(eng_wr),
    .eng_long_o(eng_long), .eng_noresp_o(eng_noresp), .eng_busy_o(eng_busy),
    .eng_done_i(eng_done), .eng_timeout_i(eng_to), .eng_crc7_i(eng_crc),
    .eng_resp_i(eng_resp), .card_busy_end_i(busy_end), .blk_evt_i(blk),
    .sdio_evt_i(sdio), .rew_timeout_i(rewto), .crc16_err_i(crc16),
    .fifo_err_i(fifo), .data_flag_i(dflag)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    bus_we = 1'b1; bus_addr = a; bus_wdata = d;
    @(posedge clk); @(negedge clk);
    bus_we = 1'b0;
  endtask

  task automatic rd(input logic [7:0] a, output logic [31:0] d);
    bus_addr = a; #1; d = bus_rdata;
  endtask

  task automatic done_pulse(input logic to, input logic crc, input logic [127:0] r);
    eng_done = 1'b1; eng_to = to; eng_crc = crc; eng_resp = r;
    @(posedge clk); @(negedge clk);
    eng_done = 1'b0; eng_to = 1'b0; eng_crc = 1'b0;
  endtask

  task automatic tick();
    @(posedge clk); @(negedge clk);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    fails++;
    $display("FAIL watchdog actual hung expected finish");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    logic [31:0] v;
    for (int i = 0; i < 4; i++) resp_m[i] = '0;
    repeat (3) @(negedge clk);
    // R1 reset state
    chk("R1 start low in reset", {31'b0, eng_start}, 0);
    rst_n = 1'b1;
    tick();
    rd(8'h00, v); chk("R1 cmd word", v, 0);
    rd(8'h04, v); chk("R1 argument", v, 0);
    for (int i = 0; i < 4; i++) begin
      rd(8'h10 + 8'(4*i), v); chk("R1 response word", v, 0);
    end
    rd(8'h20, v); chk("R1 status", v, 0);

    // R7 stray busy end is ignored
    busy_end = 1'b1; tick(); busy_end = 1'b0;
    rd(8'h20, v); chk("R7 stray busy end", v, 0);

    for (int n = 0; n < NV; n++) begin
      vec_t t;
      logic err;
      t = VECS[n];
      err = t.to | t.crc;
      wr(8'h04, t.arg);
      wr(8'h00, {16'h0, t.cmdw | 16'h8000});
      chk("R2 start pulse", {31'b0, eng_start}, 1);
      chk("R2 eng index", {26'b0, eng_idx}, {26'b0, t.cmdw[5:0]});
      chk("R2 eng flags", {27'b0, eng_busy, eng_noresp, eng_long, eng_wr, eng_rd},
          {27'b0, t.cmdw[11], t.cmdw[10], t.cmdw[9], t.cmdw[7], t.cmdw[6]});
      chk("R2 eng argument", eng_arg, t.arg);
      rd(8'h00, v); chk("R2 R4 cmd readback in flight", v, {16'h0, (t.cmdw & 16'h0EFF) | 16'h8000});
      wr(8'h00, 32'h0000_8FFF);
      chk("R2 start is one cycle", {31'b0, eng_start}, 0);
      rd(8'h00, v); chk("R3 in-flight write ignored", v, {16'h0, (t.cmdw & 16'h0EFF) | 16'h8000});
      tick();
      rd(8'h00, v); chk("R3 new held without done", {31'b0, v[15]}, 1);
      done_pulse(t.to, t.crc, t.resp);
      rd(8'h00, v); chk("R3 R4 cmd after done", v, {16'h0, (t.cmdw & 16'h0EFF) | (err ? 16'h4000 : 16'h0)});
      if (!err && !t.cmdw[10]) begin
        if (t.cmdw[9]) for (int i = 0; i < 4; i++) resp_m[i] = t.resp[32*i +: 32];
        else resp_m[0] = t.resp[31:0];
      end
      for (int i = 0; i < 4; i++) begin
        rd(8'h10 + 8'(4*i), v);
        chk(t.cmdw[10] ? "R6 response kept" : "R5 response word", v, resp_m[i]);
      end
      rd(8'h20, v); chk("R4 status error bits", v, {25'b0, t.to, 1'b0, t.crc, 4'b0});
      if (t.cmdw[11]) begin
        busy_end = 1'b1; tick(); busy_end = 1'b0;
        rd(8'h20, v); chk("R7 busy interrupt", v, 32'h400);
      end
      wr(8'h20, 32'h7F8);
      rd(8'h20, v); chk("R9 clear all", v, 0);
    end

    // R10 argument, undefined offsets, no-launch write
    wr(8'h04, 32'hA5A5_5A5A);
    rd(8'h04, v); chk("R10 argument readback", v, 32'hA5A5_5A5A);
    rd(8'h08, v); chk("R10 undefined 0x08", v, 0);
    rd(8'h24, v); chk("R10 undefined 0x24", v, 0);
    rd(8'h11, v); chk("R10 unaligned 0x11", v, 0);
    wr(8'h00, 32'h0000_0245);
    chk("R10 no start without new", {31'b0, eng_start}, 0);
    rd(8'h00, v); chk("R10 fields stored", v, 32'h0000_0245);

    // R8 data-path events and live data flag
    blk = 1; sdio = 1; rewto = 1; crc16 = 1; fifo = 1; tick();
    blk = 0; sdio = 0; rewto = 0; crc16 = 0; fifo = 0; tick();
    rd(8'h20, v); chk("R8 sticky events", v, 32'h3A8);
    dflag = 1'b1; #1;
    rd(8'h20, v); chk("R8 data flag live", v, 32'h3A9);
    wr(8'h20, 32'h001);
    rd(8'h20, v); chk("R8 data flag not clearable", v, 32'h3A9);
    dflag = 1'b0;

    // R9 partial clear and set-wins
    wr(8'h20, 32'h108);
    rd(8'h20, v); chk("R9 partial clear", v, 32'h2A0);
    blk = 1'b1;
    wr(8'h20, 32'h7F8);
    blk = 1'b0;
    rd(8'h20, v); chk("R9 set wins over clear", v, 32'h200);

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule